// File: doc/BRIEF.md
# Parallel Sequential Prefetch Buffer Set

This block holds several small prefetch queues side by side. Each queue follows one sequential run of line addresses. A cache that misses presents the missing line address on the lookup port. In the same cycle, the block compares that address against the head entry of every queue.

A head that matches and already holds its data gives a hit, and the line is returned combinationally. That queue then shifts forward by one entry and asks memory for the next line in its run. A head that matches but is still waiting for its data gives a wait result, and nothing changes. When no head matches, the queue that was least recently used is reloaded. It starts prefetching the lines that follow the missing one.

All queues share one memory request port. Grants rotate round-robin, so prefetches from different queues can be in flight at the same time. Each response comes back tagged with a queue index and a line address. It fills the entry it belongs to, or it is dropped if that entry no longer exists.

Top module: `sbuf_array`

## Requirements
- R1: Out of reset every queue is empty. `memReqValid` is low, and the first lookup is a miss (`lkHit` and `lkWait` both low).
- R2: A lookup that matches no valid head reloads the least recently used queue. Its entries are set to lkAddr+1 through lkAddr+DEPTH, none of them available, and that queue then requests those addresses in rising order, each with `memReqId` equal to its index.
- R3: A lookup whose matching head is available raises `lkHit` in the same cycle, with `lkData` equal to the line memory returned for that address. The queue's head then moves to lkAddr+1, and the queue later requests the line one past its old last entry.
- R4: A lookup whose matching head is not yet available raises `lkWait` and leaves all queue contents and the recency order unchanged. `lkHit` and `lkWait` are never high together, and both stay low when `lkValid` is low.
- R5: Recency is an ordering of the queue indices. A hit or a reload moves that queue to most recent. Out of reset the order from most to least recent is 0,1,...,NUM_BUF-1, so the first reloads take NUM_BUF-1, then NUM_BUF-2, and so on.
- R6: When several queues have unrequested entries, one request is granted per cycle in which `memReqReady` is high. The grant goes to the next requesting queue in rotating order after the last granted one, so NUM_BUF queues that are all waiting are served once each in NUM_BUF consecutive grants.
- R7: A response (`memRspId`, `memRspAddr`) fills only an entry of queue `memRspId` whose address equals `memRspAddr` and that has been requested but not yet filled. Any other response, including one for a queue that has since been reloaded, is discarded.
- R8: When more than one head matches the lookup address, the lowest-index queue decides the result and is the one that advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkValid | input | 1 | A missed line address is being looked up |
| lkAddr | input | ADDR_W | Line address looked up |
| lkHit | output | 1 | Matching head holds data (combinational) |
| lkWait | output | 1 | Matching head is still waiting for data (combinational) |
| lkData | output | LINE_W | Line returned on a hit |
| memReqValid | output | 1 | A queue has a line to request |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqAddr | output | ADDR_W | Line address requested |
| memReqId | output | IDX_W | Index of the requesting queue |
| memRspValid | input | 1 | Memory returns a line this cycle |
| memRspId | input | IDX_W | Queue index echoed from the request |
| memRspAddr | input | ADDR_W | Line address echoed from the request |
| memRspData | input | LINE_W | Returned line |

## Verification
The assertions assume that memory echoes back, with each response, the queue index and line address it was given. They also assume that every response corresponds to a request that was accepted earlier. The bench memory enforces this: it answers only requests it has recorded, in random order and after random delays, and it may answer requests whose queue has since been reloaded. The lookup stream is driven from a handful of sequential cursors, with random jumps and idle cycles. That keeps both lookup addresses and responses inside the addresses the block can legally see.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // configuration of the queue set
  localparam int NUM_BUF = 4;   // parallel queues, power of two
  localparam int DEPTH   = 4;   // entries per queue
  localparam int ADDR_W  = 16;  // line address width
  localparam int LINE_W  = 32;  // line payload width
  localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef logic [IDX_W-1:0] bufIdx_t;

  // one prefetch entry
  typedef struct packed {
    logic [ADDR_W-1:0] tag;
    logic              issued;
    logic              avail;
    logic [LINE_W-1:0] line;
  } sbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    hitEn;
    bufIdx_t hitIdx;
    logic    allocEn;
    bufIdx_t allocIdx;
    logic    grantEn;
    bufIdx_t grantIdx;
  } sbStrobe_t;
endpackage

// File: rtl/sbuf_recency.sv
module sbuf_recency
  import sbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    touchEn,
  input  bufIdx_t touchIdx,
  output bufIdx_t lruIdx
);
  bufIdx_t orderQ [NUM_BUF];
  bufIdx_t orderD [NUM_BUF];
  int      touchPos;

  always_comb begin
    touchPos = 0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (orderQ[i] == touchIdx) touchPos = i;
    end
    for (int i = 0; i < NUM_BUF; i++) begin
      if (i == 0)             orderD[i] = touchIdx;
      else if (i <= touchPos) orderD[i] = orderQ[i-1];
      else                    orderD[i] = orderQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BUF; i++) orderQ[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < NUM_BUF; i++) orderQ[i] <= orderD[i];
    end
  end

  assign lruIdx = orderQ[NUM_BUF-1];

  logic [NUM_BUF-1:0] presentMask;
  always_comb begin
    presentMask = '0;
    for (int i = 0; i < NUM_BUF; i++) presentMask[orderQ[i]] = 1'b1;
  end

  // R5: the order is always a permutation of the queue indices
  p_order_perm_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(presentMask) == NUM_BUF);

  // R5: a touched queue becomes most recent
  p_touch_front_r5: assert property (@(posedge clk) disable iff (rst)
    touchEn |=> orderQ[0] == $past(touchIdx));
endmodule

// File: rtl/sbuf_arbiter.sv
module sbuf_arbiter
  import sbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] req,
  input  logic               ready,
  output logic               anyReq,
  output bufIdx_t            pick,
  output logic [NUM_BUF-1:0] grantVec
);
  bufIdx_t ptrQ;
  bufIdx_t cand;
  logic    found;

  always_comb begin
    pick  = ptrQ;
    found = 1'b0;
    for (int k = 0; k < NUM_BUF; k++) begin
      cand = IDX_W'((int'(ptrQ) + k) % NUM_BUF);
      if (!found && req[cand]) begin
        pick  = cand;
        found = 1'b1;
      end
    end
  end

  assign anyReq   = |req;
  assign grantVec = (anyReq && ready) ? (NUM_BUF'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) ptrQ <= '0;
    else if (anyReq && ready) ptrQ <= IDX_W'((int'(pick) + 1) % NUM_BUF);
  end

  // R6: at most one grant per cycle
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec));

  // R6: a grant only goes to a requesting queue
  p_grant_req_r6: assert property (@(posedge clk) disable iff (rst)
    (grantVec != '0) |-> ((grantVec & req) == grantVec));
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           lkValid,
  input  logic [ADDR_W-1:0]              lkAddr,
  input  logic [NUM_BUF-1:0]             bufValid,
  input  logic [NUM_BUF-1:0]             headAvail,
  input  logic [NUM_BUF-1:0][ADDR_W-1:0] headTag,
  input  logic [NUM_BUF-1:0]             reqPending,
  input  logic                           memReqReady,
  output sbStrobe_t                      str,
  output logic                           lkHit,
  output logic                           lkWait,
  output logic                           memReqValid,
  output bufIdx_t                        memReqId
);
  logic [NUM_BUF-1:0] matchVec;
  bufIdx_t            matchIdx;
  logic               anyMatch;
  bufIdx_t            lruIdx;
  bufIdx_t            pick;
  logic [NUM_BUF-1:0] grantVec;
  logic               missEn;

  // parallel head compare, lowest index wins (R8)
  always_comb begin
    matchIdx = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      matchVec[b] = bufValid[b] && (headTag[b] == lkAddr);
    end
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (matchVec[b]) matchIdx = IDX_W'(b);
    end
  end

  assign anyMatch = |matchVec;
  assign lkHit    = lkValid && anyMatch && headAvail[matchIdx];
  assign lkWait   = lkValid && anyMatch && !headAvail[matchIdx];
  assign missEn   = lkValid && !anyMatch;

  sbuf_recency u_recency (
    .clk      (clk),
    .rst      (rst),
    .touchEn  (lkHit || missEn),
    .touchIdx (lkHit ? matchIdx : lruIdx),
    .lruIdx   (lruIdx)
  );

  sbuf_arbiter u_arbiter (
    .clk      (clk),
    .rst      (rst),
    .req      (reqPending),
    .ready    (memReqReady),
    .anyReq   (memReqValid),
    .pick     (pick),
    .grantVec (grantVec)
  );

  always_comb begin
    str.hitEn    = lkHit;
    str.hitIdx   = matchIdx;
    str.allocEn  = missEn;
    str.allocIdx = lruIdx;
    str.grantEn  = |grantVec;
    str.grantIdx = pick;
  end

  assign memReqId = pick;

  // R4: hit and wait are exclusive and need a lookup
  p_hit_wait_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(lkHit && lkWait) && (lkValid || (!lkHit && !lkWait)));

  // R2: a miss means no valid head carried the address
  p_miss_nomatch_r2: assert property (@(posedge clk) disable iff (rst)
    str.allocEn |-> !lkHit && !lkWait);
endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  sbStrobe_t                      str,
  input  logic [ADDR_W-1:0]              lkAddr,
  input  logic                           memRspValid,
  input  bufIdx_t                        memRspId,
  input  logic [ADDR_W-1:0]              memRspAddr,
  input  logic [LINE_W-1:0]              memRspData,
  output logic [NUM_BUF-1:0]             bufValid,
  output logic [NUM_BUF-1:0]             headAvail,
  output logic [NUM_BUF-1:0][ADDR_W-1:0] headTag,
  output logic [NUM_BUF-1:0]             reqPending,
  output logic [ADDR_W-1:0]              memReqAddr,
  output logic [LINE_W-1:0]              lkData
);
  sbEntry_t           bufQ [NUM_BUF][DEPTH];
  sbEntry_t           bufD [NUM_BUF][DEPTH];
  logic [NUM_BUF-1:0] validQ, validD;
  logic [SLOT_W-1:0]  reqSlot [NUM_BUF];
  logic [ADDR_W-1:0]  reqAddrV [NUM_BUF];
  logic [ADDR_W-1:0]  tailTag;

  // first unrequested entry per queue (requests go out in entry order)
  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      reqPending[b] = 1'b0;
      reqSlot[b]    = '0;
      reqAddrV[b]   = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
        if (!bufQ[b][e].issued) begin
          reqPending[b] = validQ[b];
          reqSlot[b]    = SLOT_W'(e);
          reqAddrV[b]   = bufQ[b][e].tag;
        end
      end
    end
  end

  // next state: fill, then grant mark, then shift or reload
  always_comb begin
    bufD    = bufQ;
    validD  = validQ;
    tailTag = bufQ[str.hitIdx][DEPTH-1].tag + ADDR_W'(1);

    if (memRspValid && validQ[memRspId]) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (bufQ[memRspId][e].tag == memRspAddr &&
            bufQ[memRspId][e].issued && !bufQ[memRspId][e].avail) begin
          bufD[memRspId][e].avail = 1'b1;
          bufD[memRspId][e].line  = memRspData;
        end
      end
    end

    if (str.grantEn) begin
      bufD[str.grantIdx][reqSlot[str.grantIdx]].issued = 1'b1;
    end

    if (str.hitEn) begin
      for (int e = 0; e < DEPTH - 1; e++) begin
        bufD[str.hitIdx][e] = bufD[str.hitIdx][e+1];
      end
      bufD[str.hitIdx][DEPTH-1] = '{tag: tailTag, issued: 1'b0, avail: 1'b0, line: '0};
    end else if (str.allocEn) begin
      validD[str.allocIdx] = 1'b1;
      for (int e = 0; e < DEPTH; e++) begin
        bufD[str.allocIdx][e] = '{tag: lkAddr + ADDR_W'(e + 1), issued: 1'b0,
                                  avail: 1'b0, line: '0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      for (int b = 0; b < NUM_BUF; b++) begin
        for (int e = 0; e < DEPTH; e++) bufQ[b][e] <= '0;
      end
    end else begin
      validQ <= validD;
      bufQ   <= bufD;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      headTag[b]   = bufQ[b][0].tag;
      headAvail[b] = bufQ[b][0].avail;
    end
  end

  assign bufValid   = validQ;
  assign memReqAddr = reqAddrV[str.grantIdx];
  assign lkData     = bufQ[str.hitIdx][0].line;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_chk
    // R2: a reload starts the queue one line past the miss, not yet filled
    p_alloc_head_r2: assert property (@(posedge clk) disable iff (rst)
      (str.allocEn && str.allocIdx == IDX_W'(g)) |=>
        (bufQ[g][0].tag == $past(lkAddr) + ADDR_W'(1)) && !bufQ[g][0].issued);

    // R3: a hit advances the head by one line
    p_hit_advance_r3: assert property (@(posedge clk) disable iff (rst)
      (str.hitEn && str.hitIdx == IDX_W'(g)) |=>
        bufQ[g][0].tag == $past(bufQ[g][0].tag) + ADDR_W'(1));

    // R7: an unchanged queue keeps its head data once filled
    p_avail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(bufQ[g][0].avail) |->
        $past(str.hitEn && str.hitIdx == IDX_W'(g)) ||
        $past(str.allocEn && str.allocIdx == IDX_W'(g)));
  end
endmodule

// File: rtl/sbuf_array.sv
module sbuf_array
  import sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkWait,
  output logic [LINE_W-1:0] lkData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [IDX_W-1:0]  memReqId,
  input  logic              memRspValid,
  input  logic [IDX_W-1:0]  memRspId,
  input  logic [ADDR_W-1:0] memRspAddr,
  input  logic [LINE_W-1:0] memRspData
);
  sbStrobe_t                      str;
  logic [NUM_BUF-1:0]             bufValid;
  logic [NUM_BUF-1:0]             headAvail;
  logic [NUM_BUF-1:0][ADDR_W-1:0] headTag;
  logic [NUM_BUF-1:0]             reqPending;

  sbuf_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .lkValid     (lkValid),
    .lkAddr      (lkAddr),
    .bufValid    (bufValid),
    .headAvail   (headAvail),
    .headTag     (headTag),
    .reqPending  (reqPending),
    .memReqReady (memReqReady),
    .str         (str),
    .lkHit       (lkHit),
    .lkWait      (lkWait),
    .memReqValid (memReqValid),
    .memReqId    (memReqId)
  );

  sbuf_datapath u_datapath (
    .clk         (clk),
    .rst         (rst),
    .str         (str),
    .lkAddr      (lkAddr),
    .memRspValid (memRspValid),
    .memRspId    (memRspId),
    .memRspAddr  (memRspAddr),
    .memRspData  (memRspData),
    .bufValid    (bufValid),
    .headAvail   (headAvail),
    .headTag     (headTag),
    .reqPending  (reqPending),
    .memReqAddr  (memReqAddr),
    .lkData      (lkData)
  );

  // R1: first cycle out of reset is idle
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !memReqValid && !lkHit && !lkWait);
endmodule

// File: tb/test_sbuf_array.sv
module test_sbuf_array;
  import sbuf_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lkValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              lkHit, lkWait;
  logic [LINE_W-1:0] lkData;
  logic              memReqValid;
  logic              memReqReady = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic [IDX_W-1:0]  memReqId;
  logic              memRspValid = 1'b0;
  logic [IDX_W-1:0]  memRspId = '0;
  logic [ADDR_W-1:0] memRspAddr = '0;
  logic [LINE_W-1:0] memRspData = '0;

  always #4 clk = ~clk;   // 125 MHz

  sbuf_array i_sbuf_array (.*);

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench reference state
  logic [ADDR_W-1:0] mHead [NUM_BUF];
  bit                mValid [NUM_BUF];
  int                mOrder [NUM_BUF];
  logic [IDX_W+ADDR_W-1:0] pendQ [$];
  int                rspMode = 0;      // 0 random, 1 selected, 2 hold
  int                selId = 0;
  logic [ADDR_W-1:0] selLo = '0, selHi = '0;
  bit                nextValid = 1'b0;
  logic [ADDR_W-1:0] nextAddr = '0;
  bit                nextReady = 1'b0;
  int                res = 0;          // 0 idle, 1 hit, 2 wait, 3 miss
  logic [ADDR_W-1:0] watchAddr = '1;
  int                watchId = -1;
  int                grantLog [$];
  int unsigned       seedVal;

  function automatic logic [LINE_W-1:0] lineOf(logic [ADDR_W-1:0] a);
    return {a * 16'd7 + 16'h3C1, ~a};
  endfunction

  function automatic void touch(int t);
    int p = 0;
    for (int i = 0; i < NUM_BUF; i++) if (mOrder[i] == t) p = i;
    for (int i = p; i > 0; i--) mOrder[i] = mOrder[i-1];
    mOrder[0] = t;
  endfunction

  function automatic int modelMatch(logic [ADDR_W-1:0] a);
    for (int b = 0; b < NUM_BUF; b++) if (mValid[b] && mHead[b] == a) return b;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic evalCycle();
    int m;
    logic [ADDR_W-1:0] d;
    if (memReqValid && memReqReady) begin
      d = memReqAddr - mHead[memReqId];
      // R2: every request lies in the requesting queue's window
      check(mValid[memReqId] && d < ADDR_W'(DEPTH), "R2", "request outside window",
            memReqAddr, mHead[memReqId]);
      pendQ.push_back({memReqId, memReqAddr});
      grantLog.push_back(int'(memReqId));
      if (memReqAddr == watchAddr) watchId = int'(memReqId);
    end
    res = 0;
    if (!lkValid) begin
      check(!lkHit && !lkWait, "R4", "hit/wait without lookup", {lkHit, lkWait}, 0);
    end else begin
      m = modelMatch(lkAddr);
      if (lkHit) begin
        res = 1;
        check(m >= 0 && !lkWait, "R3", "hit without matching head", lkAddr, m);
        check(lkData == lineOf(lkAddr), "R3", "hit data", lkData, lineOf(lkAddr));
        if (m >= 0) begin mHead[m] = mHead[m] + 1'b1; touch(m); end
      end else if (lkWait) begin
        res = 2;
        check(m >= 0, "R4", "wait without matching head", lkAddr, m);
      end else begin
        res = 3;
        check(m < 0, "R2", "miss with matching head", m, -1);
        m = mOrder[NUM_BUF-1];   // R5 victim
        mValid[m] = 1'b1;
        mHead[m] = lkAddr + 1'b1;
        touch(m);
      end
    end
  endtask

  task automatic step();
    int k;
    @(posedge clk);
    #1;
    lkValid = nextValid;
    lkAddr = nextAddr;
    memReqReady = nextReady;
    memRspValid = 1'b0;
    if (rspMode == 0 && pendQ.size() > 0 && ($urandom % 3 == 0)) begin
      k = int'($urandom % pendQ.size());
      {memRspId, memRspAddr} = pendQ[k];
      memRspData = lineOf(memRspAddr);
      memRspValid = 1'b1;
      pendQ.delete(k);
    end else if (rspMode == 1) begin
      for (int i = 0; i < pendQ.size(); i++) begin
        if (!memRspValid && int'(pendQ[i][IDX_W+ADDR_W-1:ADDR_W]) == selId &&
            pendQ[i][ADDR_W-1:0] >= selLo && pendQ[i][ADDR_W-1:0] <= selHi) begin
          {memRspId, memRspAddr} = pendQ[i];
          memRspData = lineOf(memRspAddr);
          memRspValid = 1'b1;
          pendQ.delete(i);
        end
      end
    end
    #4;
    evalCycle();
  endtask

  task automatic look(logic [ADDR_W-1:0] a);
    nextValid = 1'b1; nextAddr = a; step(); nextValid = 1'b0;
  endtask

  task automatic idle(int n);
    nextValid = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] cur [6];
    int c, firstDup, lo;
    seedVal = $urandom(32'h5EED_0042);
    for (int b = 0; b < NUM_BUF; b++) begin mValid[b] = 0; mHead[b] = '0; mOrder[b] = b; end

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    rspMode = 2;
    idle(1);
    // R1: idle after reset
    check(!memReqValid, "R1", "request after reset", memReqValid, 0);
    look(16'h0100);
    check(res == 3, "R1", "first lookup not a miss", res, 3);

    // R6: four waiting queues served once each
    look(16'h0200); look(16'h0300); look(16'h0400);
    grantLog.delete();
    nextReady = 1'b1;
    idle(NUM_BUF);
    check(grantLog.size() == NUM_BUF, "R6", "grant count", grantLog.size(), NUM_BUF);
    if (grantLog.size() == NUM_BUF) begin
      for (int i = 0; i < NUM_BUF; i++)
        for (int j = i + 1; j < NUM_BUF; j++)
          check(grantLog[i] != grantLog[j], "R6", "repeated grant", grantLog[j], -1);
    end
    idle(12);

    // R4: matching head not filled
    look(16'h0201);
    check(res == 2, "R4", "unfilled head not wait", res, 2);
    // R5: first allocation went to the last index, now reused
    check(mOrder[NUM_BUF-1] == NUM_BUF - 1, "R5", "initial victim order", mOrder[NUM_BUF-1], NUM_BUF-1);
    look(16'h0900);
    // R7: stale responses for the reloaded queue are dropped
    rspMode = 1; selId = NUM_BUF - 1; selLo = 16'h0101; selHi = 16'h0104;
    idle(8);
    rspMode = 2;
    look(16'h0901);
    check(res == 2, "R7", "stale fill reached new head", res, 2);
    look(16'h0101);
    check(res == 3, "R7", "old address still present", res, 3);

    rspMode = 0;
    idle(60);

    // R8: two queues with the same head
    look(16'h0800);
    look(16'h0800);
    firstDup = modelMatch(16'h0801);
    check(firstDup >= 0, "R8", "duplicate head missing", firstDup, 0);
    lo = firstDup;
    watchAddr = 16'h0801 + ADDR_W'(DEPTH);
    watchId = -1;
    for (int i = 0; i < 300 && res != 1; i++) look(16'h0801);
    check(res == 1, "R8", "duplicate head never hit", res, 1);
    idle(40);
    check(watchId == lo, "R8", "wrong queue advanced", watchId, lo);
    watchAddr = '1;

    // R3 directed run: follow a stream until it hits repeatedly
    look(16'h1000);
    for (int i = 0; i < 6; i++) begin
      for (int t = 0; t < 200; t++) begin
        look(16'h1001 + ADDR_W'(i));
        if (res == 1) break;
      end
      check(res == 1, "R3", "sequential stream hit", res, 1);
    end

    // random interleaved streams
    for (int i = 0; i < 6; i++) cur[i] = ADDR_W'(16'h2000 + i * 16'h0400);
    for (int n = 0; n < 6000; n++) begin
      nextReady = ($urandom % 4) != 0;
      if ($urandom % 10 == 0) begin
        idle(1);
      end else begin
        c = int'($urandom % 6);
        if ($urandom % 40 == 0) cur[c] = ADDR_W'($urandom);
        look(cur[c]);
        if (res == 1 || res == 3) cur[c] = cur[c] + 1'b1;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule